// File: doc/BRIEF.md
# Fractional-N Divide-Ratio Sequencer

This block picks, once per phase-comparator period, the whole-number ratio that the RF pulse-swallow feedback divider counts in that period. Over time the chosen ratios average to 16·N + A + 3 + F/2^20. Here N is the main count, A is the swallow count, and F is a 20-bit fractional numerator. A first-order phase accumulator of modulus 2^20 adds the conditioned numerator on every period strobe. Whenever the accumulator wraps, the swallow count for that period goes up by one, which lengthens that period's division by exactly one VCO cycle.

Before use, the numerator always has its least significant bit forced high. An even setting is therefore raised by one, and an odd setting passes through unchanged. The settings N, A and F are sampled only on a strobe, so a count already in progress never sees a change. When F is loaded with a different value, the accumulator restarts from zero. The block presents the per-period main count and swallow count, the wrap flag, and the combined total ratio. All four are registered and change only on the strobe edge.

Top module: `fracn_ratio_seq`

## Requirements
- R1: While reset is held and right after it, main_cnt, swallow_cnt, ratio_total and carry_out are all zero, and the accumulator is empty.
- R2: On a clock edge with ref_strobe high, main_cnt takes n_in and swallow_cnt takes a_in plus that period's carry. Without a strobe, all outputs hold, and input changes between strobes have no effect until the next strobe.
- R3: ratio_total always equals 16·main_cnt + swallow_cnt + 3 after the first strobe.
- R4: Each strobe adds the effective numerator to the accumulator modulo 2^ACC_W. carry_out is 1 for that period exactly when the sum reaches 2^ACC_W.
- R5: The effective numerator is f_in with bit 0 forced to 1 (an even F becomes F+1, an odd F is kept).
- R6: A strobe that presents an f_in different from the last sampled one restarts the accumulator from zero: its sum is the effective numerator alone, so that period's carry_out is 0.
- R7: Over any 2^ACC_W consecutive strobes with an unchanged f_in, the carries add up exactly to the effective numerator.
- R8: At the upper corner (A = 15 with a carry), swallow_cnt is 16 and ratio_total reaches 16·N + 19. N = 5 and N = 127 are handled without wrap.
- R9: Clock edges without a strobe leave the accumulator untouched, so the carry sequence resumes after a pause exactly where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_strobe | input | 1 | One-cycle mark of a phase-comparator period boundary |
| n_in | input | N_W (7) | Main counter setting |
| a_in | input | A_W (4) | Swallow counter setting |
| f_in | input | ACC_W (20) | Fractional numerator |
| main_cnt | output | N_W (7) | Main count for the current period |
| swallow_cnt | output | A_W+1 (5) | Swallow count for the current period, including the extra count |
| ratio_total | output | RATIO_W (12) | Total division ratio for the current period |
| carry_out | output | 1 | Accumulator wrap flag for the current period |

## Verification
The bench builds the block with an 8-bit accumulator and sweeps every numerator from 0 to 255. For each one it runs long back-to-back strobe trains with N and A varied alongside F. Every period is compared against an arithmetic model, and both a window aligned to the load and a shifted 256-strobe window are summed. The sweep separates the odd-forcing rule from a plain accumulator, because each even F must yield F+1 carries. The shifted window shows that restart-on-load and wrap handling are correct beyond the first cycle. Directed sequences then cover three further cases: inputs changed between strobes (these must be ignored), strobe pauses in the middle of a train (the carry pattern must continue), and the all-ones corner, where A = 15 meets a carry at N = 127 and gives the largest ratio.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

   // Number of bits needed to hold the value v (at least 1).
   function automatic int bits_for(input longint unsigned v);
      int w;
      w = 1;
      while ((longint'(1) << w) <= v) w++;
      return w;
   endfunction

   // True when v is a non-zero power of two.
   function automatic bit is_pow2(input longint unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Base-2 logarithm of a power of two.
   function automatic int log2_exact(input longint unsigned v);
      int s;
      s = 0;
      while ((longint'(1) << s) < v) s++;
      return s;
   endfunction

   // Width of the largest ratio: PRESC*Nmax + (Amax+1) + OFFSET.
   function automatic int ratio_width(input int n_w, input int a_w,
                                      input int presc, input int offset);
      longint unsigned top;
      top = longint'(presc) * ((longint'(1) << n_w) - 1)
            + (longint'(1) << a_w) + longint'(offset);
      return bits_for(top);
   endfunction

endpackage

// File: rtl/fracn_num_cond.sv
module fracn_num_cond #(
   parameter int ACC_W     = 20,
   parameter bit ODD_FORCE = 1'b1
) (
   input  logic [ACC_W-1:0] f_raw,
   output logic [ACC_W-1:0] f_eff
);

   generate
      if (ACC_W < 2) begin : g_bad_width
         $error("fracn_num_cond: ACC_W must be at least 2");
      end

      if (ODD_FORCE) begin : g_odd
         // Bit 0 is forced high, so the numerator is always odd.
         assign f_eff = {f_raw[ACC_W-1:1], 1'b1};
      end else begin : g_pass
         assign f_eff = f_raw;
      end
   endgenerate

endmodule

// File: rtl/fracn_accum.sv
module fracn_accum #(
   parameter int ACC_W     = 20,
   parameter bit ODD_FORCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   input  logic [ACC_W-1:0] f_eff,
   output logic             carry_nxt
);

   localparam int SUM_W = ACC_W + 1;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] base;
   logic [SUM_W-1:0] sum;

   // A restart drops the old phase, so the sum holds the numerator alone.
   assign base      = restart ? '0 : acc_q;
   assign sum       = {1'b0, base} + {1'b0, f_eff};
   assign carry_nxt = sum[ACC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (step) begin
         acc_q <= sum[ACC_W-1:0];
      end
   end

   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(acc_q)); // R9

   generate
      if (ODD_FORCE) begin : g_chk_odd
         AST_ODD_NUMERATOR: assert property (@(posedge clk) disable iff (!rst_n)
            step |-> f_eff[0]); // R5
      end
   endgenerate

endmodule

// File: rtl/fracn_ratio_calc.sv
module fracn_ratio_calc #(
   parameter int N_W     = 7,
   parameter int A_W     = 4,
   parameter int RATIO_W = 12,
   parameter int PRESC   = 16,
   parameter int OFFSET  = 3
) (
   input  logic [N_W-1:0]     n_val,
   input  logic [A_W:0]       sw_val,
   output logic [RATIO_W-1:0] ratio
);

   import fracn_pkg::*;

   localparam bit PRESC_POW2 = is_pow2(PRESC);
   localparam int PRESC_SH   = log2_exact(PRESC);

   logic [RATIO_W-1:0] n_ext;
   logic [RATIO_W-1:0] prod;

   assign n_ext = RATIO_W'(n_val);

   generate
      if (PRESC < 2) begin : g_bad_presc
         $error("fracn_ratio_calc: PRESC must be at least 2");
      end

      if (PRESC_POW2) begin : g_shift
         // A power-of-two prescaler needs only a shift.
         assign prod = n_ext << PRESC_SH;
      end else begin : g_mult
         assign prod = n_ext * RATIO_W'(PRESC);
      end
   endgenerate

   assign ratio = prod + RATIO_W'(sw_val) + RATIO_W'(OFFSET);

endmodule

// File: rtl/fracn_ratio_seq.sv
module fracn_ratio_seq #(
   parameter int ACC_W     = 20,
   parameter int N_W       = 7,
   parameter int A_W       = 4,
   parameter int PRESC     = 16,
   parameter int OFFSET    = 3,
   parameter bit ODD_FORCE = 1'b1,
   parameter int RATIO_W   = fracn_pkg::ratio_width(N_W, A_W, PRESC, OFFSET)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_strobe,
   input  logic [N_W-1:0]     n_in,
   input  logic [A_W-1:0]     a_in,
   input  logic [ACC_W-1:0]   f_in,
   output logic [N_W-1:0]     main_cnt,
   output logic [A_W:0]       swallow_cnt,
   output logic [RATIO_W-1:0] ratio_total,
   output logic               carry_out
);

   localparam int MIN_RATIO_W = fracn_pkg::ratio_width(N_W, A_W, PRESC, OFFSET);

   generate
      if (RATIO_W < MIN_RATIO_W) begin : g_bad_ratio_w
         $error("fracn_ratio_seq: RATIO_W too narrow for the largest ratio");
      end
      if (N_W < 3 || A_W < 1) begin : g_bad_counts
         $error("fracn_ratio_seq: counter widths too small");
      end
   endgenerate

   logic [ACC_W-1:0]   f_last_q;
   logic [ACC_W-1:0]   f_eff;
   logic               restart;
   logic               carry_nxt;
   logic [A_W:0]       sw_nxt;
   logic [RATIO_W-1:0] ratio_nxt;

   // A numerator that differs from the last one sampled restarts the phase.
   assign restart = (f_in != f_last_q);

   fracn_num_cond #(
      .ACC_W     (ACC_W),
      .ODD_FORCE (ODD_FORCE)
   ) num_cond_i (
      .f_raw (f_in),
      .f_eff (f_eff)
   );

   fracn_accum #(
      .ACC_W     (ACC_W),
      .ODD_FORCE (ODD_FORCE)
   ) accum_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (ref_strobe),
      .restart   (restart),
      .f_eff     (f_eff),
      .carry_nxt (carry_nxt)
   );

   // The extra count is applied through the swallow counter.
   assign sw_nxt = {1'b0, a_in} + {{A_W{1'b0}}, carry_nxt};

   fracn_ratio_calc #(
      .N_W     (N_W),
      .A_W     (A_W),
      .RATIO_W (RATIO_W),
      .PRESC   (PRESC),
      .OFFSET  (OFFSET)
   ) ratio_calc_i (
      .n_val  (n_in),
      .sw_val (sw_nxt),
      .ratio  (ratio_nxt)
   );

   // Settings and results are taken only at a period boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_last_q    <= '0;
         main_cnt    <= '0;
         swallow_cnt <= '0;
         ratio_total <= '0;
         carry_out   <= 1'b0;
      end else if (ref_strobe) begin
         f_last_q    <= f_in;
         main_cnt    <= n_in;
         swallow_cnt <= sw_nxt;
         ratio_total <= ratio_nxt;
         carry_out   <= carry_nxt;
      end
   end

   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_strobe |=> $stable(ratio_total) && $stable(main_cnt)
                      && $stable(swallow_cnt) && $stable(carry_out)); // R2

   AST_LOAD_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      ref_strobe && restart |=> !carry_out); // R6

   AST_CARRY_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |-> swallow_cnt != '0); // R8

   AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      ref_strobe |=> ratio_total >= RATIO_W'(OFFSET)); // R3

endmodule

// File: tb/fracn_ratio_seq_tb_top.sv
module fracn_ratio_seq_tb_top;

   localparam int AW  = 8;
   localparam int MOD = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_strobe = 1'b0;
   logic [6:0]    n_in = '0;
   logic [3:0]    a_in = '0;
   logic [AW-1:0] f_in = '0;
   logic [6:0]    main_cnt;
   logic [4:0]    swallow_cnt;
   logic [11:0]   ratio_total;
   logic          carry_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_acc = 0;
   int m_flast = 0;
   bit hist [0:511];

   always #5 clk = ~clk;

   fracn_ratio_seq #(.ACC_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_strobe(ref_strobe),
      .n_in(n_in), .a_in(a_in), .f_in(f_in),
      .main_cnt(main_cnt), .swallow_cnt(swallow_cnt),
      .ratio_total(ratio_total), .carry_out(carry_out));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // One strobed period; returns the carry expected for it.
   task automatic strobe_cycle(input int n, input int a, input int f, output bit c);
      int fe, sum;
      bit load;
      @(negedge clk);
      n_in = 7'(n); a_in = 4'(a); f_in = AW'(f); ref_strobe = 1'b1;
      fe   = f | 1;                                   // R5 odd forcing
      load = (f != m_flast);
      sum  = (load ? 0 : m_acc) + fe;
      c    = (sum >= MOD);
      m_acc = sum % MOD;
      m_flast = f;
      @(posedge clk); #1;
      chk(main_cnt == 7'(n), "R2 main", main_cnt, n);
      chk(swallow_cnt == 5'(a + c), "R2 swallow", swallow_cnt, a + c);
      chk(ratio_total == 12'(16*n + a + c + 3), "R3 ratio", ratio_total, 16*n + a + c + 3);
      if (load) chk(carry_out == 1'b0, "R6 restart carry", carry_out, 0);
      else      chk(carry_out == c, "R4 carry", carry_out, c);
   endtask

   task automatic idle(input int cyc);
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         ref_strobe = 1'b0;
      end
   endtask

   initial begin
      bit c;
      int s1, s2, seen16;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(main_cnt == 0 && swallow_cnt == 0 && ratio_total == 0 && carry_out == 0,
          "R1 reset outputs", ratio_total, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ratio_total == 0 && carry_out == 0, "R1 after reset", ratio_total, 0);

      // R4 R5 R7: exhaustive numerator sweep, two 256-strobe windows each
      for (int f = 0; f < MOD; f++) begin
         for (int k = 0; k < 280; k++) begin
            strobe_cycle(5 + (f % 123), f % 16, f, c);
            hist[k] = c;
         end
         s1 = 0; s2 = 0;
         for (int k = 0; k < MOD; k++) begin
            s1 += hist[k];
            s2 += hist[k + 24];
         end
         chk(s1 == (f | 1), "R7 window at load", s1, f | 1);
         chk(s2 == (f | 1), "R7 shifted window R5", s2, f | 1);
      end

      // R2: inputs changed between strobes are ignored
      strobe_cycle(20, 3, 100, c);
      idle(1);
      n_in = 7'd99; a_in = 4'd9; f_in = AW'(7);
      repeat (5) @(negedge clk);
      chk(main_cnt == 7'd20, "R2 hold main", main_cnt, 20);
      chk(swallow_cnt == 5'd3, "R2 hold swallow", swallow_cnt, 3);
      chk(ratio_total == 12'(16*20 + 3 + 3), "R2 hold ratio", ratio_total, 326);
      strobe_cycle(99, 9, 7, c);

      // R9: pauses inside a train keep the phase
      for (int k = 0; k < 300; k++) begin
         strobe_cycle(40, 6, 77, c);
         hist[k] = c;
         if (k % 37 == 5) idle(3);
      end
      s1 = 0;
      for (int k = 30; k < 30 + MOD; k++) s1 += hist[k];
      chk(s1 == 77, "R9 window across pauses", s1, 77);

      // R6: new numerator mid-train restarts from zero
      for (int k = 0; k < 10; k++) strobe_cycle(9, 1, 200, c);
      strobe_cycle(9, 1, 201, c);
      chk(c == 0, "R6 restart model", c, 0);

      // R8: corners of N and A
      seen16 = 0;
      for (int k = 0; k < 20; k++) begin
         strobe_cycle(127, 15, 255, c);
         if (swallow_cnt == 5'd16 && ratio_total == 12'(16*127 + 19)) seen16++;
      end
      chk(seen16 > 0, "R8 max ratio seen", seen16, 1);
      for (int k = 0; k < 20; k++) strobe_cycle(5, 0, 2, c);
      chk(main_cnt == 7'd5, "R8 min N", main_cnt, 5);

      idle(2);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule